// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is a single down-counting channel of an interval timer. It counts on a count-clock enable (`cnt_en`), which is a one-cycle pulse in the system clock domain. It has a gate input and one output pin. A register interface outside the block issues a load strobe that carries a reload value and a 3-bit counting mode. The channel then produces an interrupt-on-terminal-count level, a retriggerable one-shot, a periodic rate pulse, a square wave, or a single low strobe. The mode that is selected sets both the output waveform and how the gate is used.

The live count and the output level are presented continuously, so a surrounding register file can read them back. Counting is binary only. A reload value of zero stands for the full range, 2^WIDTH ticks.

Top module: `interval_channel`

## Requirements
- R1: After reset the count is 0 and `out` is high. Ticks have no effect until the first load.
- R2: At the clock edge that samples `load`, the count takes the reload value and the new mode takes effect. In mode 3 an odd reload value is first rounded up to the next even value. At that same edge `out` goes low in mode 0 and high in every other mode. A load takes priority over a gate edge and over a tick in the same cycle.
- R3: A reload value of 0 acts as 65536. In mode 0 the first tick after loading 0 gives count 16'hFFFF, and `out` stays low.
- R4: In modes 0, 1, 4 and 5 each counting tick lowers the count by one, wrapping from 0 to 16'hFFFF.
- R5: In mode 0 `out` goes high on the tick that moves the count from 1 to 0, and it stays high until the next load.
- R6: In modes 1 and 5 counting starts only after a rising gate edge, and the gate level has no other effect. Every rising edge reloads the count. In mode 1 `out` goes low on the trigger and returns high on the tick that reaches count 0.
- R7: In modes 4 and 5 `out` goes low on the tick that moves the count from 1 to 0. It returns high on the next tick.
- R8: In mode 2 the count steps down by one. `out` is low while the count is 1. The following tick reloads the reload value and drives `out` high again.
- R9: In mode 3 the count steps down by two, and on the tick taken at count 2 the channel reloads and toggles `out`. For a reload value N of 2 or more, the high half lasts ceil(N/2) ticks and the low half lasts floor(N/2) ticks.
- R10: In modes 2 and 3 a low gate freezes the count and forces `out` high at the next clock edge. A rising gate edge restarts the count from its start value, with `out` high.
- R11: In modes 0 and 4 a low gate freezes the count. A rising gate edge does not reload it.
- R12: Mode codes are decoded so that 6 behaves as mode 2 and 7 behaves as mode 3. When mode bit 1 is set, bit 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count-clock enable, one pulse per tick |
| gate | input | 1 | Gate level, synchronous to `clk` |
| load | input | 1 | Load strobe from the register interface |
| load_val | input | WIDTH | Reload value (0 means 2^WIDTH) |
| mode | input | 3 | Counting mode, captured on `load` |
| count | output | WIDTH | Live count value |
| out | output | 1 | Channel output level |

## Verification
Every result sits in a register and appears after a single clock edge. A load or a gate change takes effect at the first edge that samples it, and a tick takes effect at the edge that sees `cnt_en` high. The bench changes inputs only on the falling edge. It reads `count` and `out` at the following falling edge, so each check covers exactly one rising edge. A waveform is then walked tick by tick, with the expected count and level worked out by hand from the requirements.

// File: rtl/ichan_pkg.sv
package ichan_pkg;

  typedef enum logic [2:0] {
    M_INT     = 3'd0,
    M_ONESHOT = 3'd1,
    M_RATE    = 3'd2,
    M_SQUARE  = 3'd3,
    M_SWSTB   = 3'd4,
    M_HWSTB   = 3'd5
  } cmode_e;

  // codes with bit 1 set fold onto the periodic modes
  function automatic cmode_e norm_mode(input logic [2:0] m);
    return cmode_e'(m[1] ? {1'b0, m[1:0]} : m);
  endfunction

  function automatic logic waits_trigger(input cmode_e m);
    return (m == M_ONESHOT) || (m == M_HWSTB);
  endfunction

  function automatic logic is_periodic(input cmode_e m);
    return (m == M_RATE) || (m == M_SQUARE);
  endfunction

endpackage

// File: rtl/ichan_gate_sense.sv
module ichan_gate_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);
  logic gate_q;

  always_ff @(posedge clk) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate & ~gate_q;
endmodule

// File: rtl/ichan_counter.sv
module ichan_counter
  import ichan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             gate_rise,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  cmode_e           new_mode,
  input  logic             out_lvl,
  output logic [WIDTH-1:0] count,
  output cmode_e           mode_q,
  output logic             step,
  output logic             retrig,
  output logic             running
);
  localparam logic [WIDTH-1:0] C1 = WIDTH'(1);
  localparam logic [WIDTH-1:0] C2 = WIDTH'(2);

  logic [WIDTH-1:0] reload_q;
  logic             loaded_q;
  logic             trig_q;

  // high half of a square wave: odd values round up to even
  function automatic logic [WIDTH-1:0] hi_half(input logic [WIDTH-1:0] n);
    return n[0] ? n + C1 : n;
  endfunction

  function automatic logic [WIDTH-1:0] lo_half(input logic [WIDTH-1:0] n);
    return {n[WIDTH-1:1], 1'b0};
  endfunction

  function automatic logic [WIDTH-1:0] start_val(input cmode_e m,
                                                 input logic [WIDTH-1:0] n);
    return (m == M_SQUARE) ? hi_half(n) : n;
  endfunction

  function automatic logic [WIDTH-1:0] step_val(input cmode_e m,
                                                input logic [WIDTH-1:0] c,
                                                input logic [WIDTH-1:0] n,
                                                input logic hi);
    case (m)
      M_RATE:   return (c == C1) ? n : c - C1;
      M_SQUARE: return (c == C2) ? (hi ? lo_half(n) : hi_half(n)) : c - C2;
      default:  return c - C1;
    endcase
  endfunction

  assign retrig  = gate_rise & loaded_q & (mode_q != M_INT) & (mode_q != M_SWSTB);
  assign running = loaded_q & (waits_trigger(mode_q) ? trig_q : 1'b1);
  assign step    = cnt_en & running & (waits_trigger(mode_q) | gate);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count    <= '0;
      reload_q <= '0;
      mode_q   <= M_INT;
      loaded_q <= 1'b0;
      trig_q   <= 1'b0;
    end else if (load) begin
      count    <= start_val(new_mode, load_val);
      reload_q <= load_val;
      mode_q   <= new_mode;
      loaded_q <= 1'b1;
      trig_q   <= 1'b0;
    end else if (retrig) begin
      count    <= start_val(mode_q, reload_q);
      trig_q   <= 1'b1;
    end else if (step) begin
      count    <= step_val(mode_q, count, reload_q, out_lvl);
    end
  end
endmodule

// File: rtl/ichan_out_logic.sv
module ichan_out_logic
  import ichan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  cmode_e           new_mode,
  input  cmode_e           mode_q,
  input  logic             retrig,
  input  logic             step,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic [WIDTH-1:0] count,
  output logic             out
);
  localparam logic [WIDTH-1:0] C1 = WIDTH'(1);
  localparam logic [WIDTH-1:0] C2 = WIDTH'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out <= 1'b1;
    end else if (load) begin
      out <= (new_mode != M_INT);
    end else if (retrig) begin
      out <= (mode_q != M_ONESHOT);
    end else if (is_periodic(mode_q) && !gate) begin
      out <= 1'b1;
    end else begin
      case (mode_q)
        M_INT, M_ONESHOT: if (step && count == C1) out <= 1'b1;
        M_RATE:           if (step) out <= (count != C2);
        M_SQUARE:         if (step && count == C2) out <= ~out;
        M_SWSTB, M_HWSTB: if (cnt_en) out <= !(step && count == C1);
        default:          ;
      endcase
    end
  end
endmodule

// File: rtl/interval_channel.sv
module interval_channel
  import ichan_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             gate,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  input  logic [2:0]       mode,
  output logic [WIDTH-1:0] count,
  output logic             out
);
  cmode_e new_mode;
  cmode_e mode_q;
  logic   gate_rise;
  logic   ev_step;
  logic   ev_retrig;
  logic   running;

  assign new_mode = norm_mode(mode);

  ichan_gate_sense u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  ichan_counter #(.WIDTH(WIDTH)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnt_en    (cnt_en),
    .gate      (gate),
    .gate_rise (gate_rise),
    .load      (load),
    .load_val  (load_val),
    .new_mode  (new_mode),
    .out_lvl   (out),
    .count     (count),
    .mode_q    (mode_q),
    .step      (ev_step),
    .retrig    (ev_retrig),
    .running   (running)
  );

  ichan_out_logic #(.WIDTH(WIDTH)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .new_mode (new_mode),
    .mode_q   (mode_q),
    .retrig   (ev_retrig),
    .step     (ev_step),
    .cnt_en   (cnt_en),
    .gate     (gate),
    .count    (count),
    .out      (out)
  );
endmodule

// File: rtl/ichan_checker.sv
module ichan_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_en,
  input logic             gate,
  input logic             load,
  input logic [WIDTH-1:0] load_val,
  input logic [2:0]       mode,
  input logic [WIDTH-1:0] count,
  input logic             out,
  input logic [2:0]       mode_q,
  input logic             ev_step,
  input logic             ev_retrig,
  input logic             running
);
  logic one_step;
  assign one_step = (mode_q == 3'd0) || (mode_q == 3'd1) ||
                    (mode_q == 3'd4) || (mode_q == 3'd5);

  // R2
  load_mode0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode == 3'd0) |=> (count == $past(load_val) && !out));

  // R4
  dec_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && one_step && !load && !ev_retrig) |=> (count == $past(count) - 1'b1));

  // R5
  term_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && mode_q == 3'd0 && count == WIDTH'(1) && !load) |=> out);

  // R6
  wait_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && !running && !load && !ev_retrig) |=> $stable(count));

  // R8
  rate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && mode_q == 3'd2 && count == WIDTH'(2) && !load && !ev_retrig)
      |=> (!out && count == WIDTH'(1)));

  // R9
  sq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_step && mode_q == 3'd3 && count != WIDTH'(2) && !load && !ev_retrig)
      |=> (count == $past(count) - 2'd2 && $stable(out)));

  // R10
  gate_low_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !gate && (mode_q == 3'd2 || mode_q == 3'd3)) |=> out);

  // R12
  alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode[1]) |=> (mode_q == {1'b0, $past(mode[1:0])}));
endmodule

bind interval_channel ichan_checker #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cnt_en    (cnt_en),
  .gate      (gate),
  .load      (load),
  .load_val  (load_val),
  .mode      (mode),
  .count     (count),
  .out       (out),
  .mode_q    (mode_q),
  .ev_step   (ev_step),
  .ev_retrig (ev_retrig),
  .running   (running)
);

// File: tb/test_interval_channel.sv
module test_interval_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic        gate = 1'b0;
  logic        load = 1'b0;
  logic [15:0] load_val = '0;
  logic [2:0]  mode = '0;
  logic [15:0] count;
  logic        out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  interval_channel #(.WIDTH(16)) i_interval_channel (
    .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .gate(gate), .load(load),
    .load_val(load_val), .mode(mode), .count(count), .out(out)
  );

  // every task starts and ends at a falling edge
  task automatic chk(input string req, input logic [15:0] ec, input logic eo);
    total++;
    if (count !== ec || out !== eo) begin
      fails++;
      $display("FAIL %s: count=%h out=%b expected count=%h out=%b",
               req, count, out, ec, eo);
    end
  endtask

  task automatic cyc();
    cnt_en = 1'b1;
    @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic do_load(input logic [2:0] m, input logic [15:0] v);
    load = 1'b1; mode = m; load_val = v;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic set_gate(input logic v);
    gate = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", 16'd0, 1'b1);
    set_gate(1'b1);
    cyc(); chk("R1", 16'd0, 1'b1);
  endtask

  task automatic t_mode0();
    do_load(3'd0, 16'd3); chk("R2", 16'd3, 1'b0);
    cyc(); chk("R4", 16'd2, 1'b0);
    cyc(); chk("R4", 16'd1, 1'b0);
    cyc(); chk("R5", 16'd0, 1'b1);
    cyc(); chk("R4", 16'hFFFF, 1'b1);
    set_gate(1'b0);
    cyc(); chk("R11", 16'hFFFF, 1'b1);
    set_gate(1'b1); chk("R11", 16'hFFFF, 1'b1);
    do_load(3'd0, 16'd0); chk("R3", 16'd0, 1'b0);
    cyc(); chk("R3", 16'hFFFF, 1'b0);
    do_load(3'd0, 16'd10);
    cyc(); cyc(); chk("R4", 16'd8, 1'b0);
    do_load(3'd0, 16'd2); chk("R2", 16'd2, 1'b0);
    cyc(); cyc(); chk("R5", 16'd0, 1'b1);
  endtask

  task automatic t_mode1();
    set_gate(1'b0);
    do_load(3'd1, 16'd3); chk("R2", 16'd3, 1'b1);
    cyc(); chk("R6", 16'd3, 1'b1);
    set_gate(1'b1); chk("R6", 16'd3, 1'b0);
    cyc(); chk("R6", 16'd2, 1'b0);
    cyc(); chk("R6", 16'd1, 1'b0);
    cyc(); chk("R6", 16'd0, 1'b1);
    set_gate(1'b0);
    cyc(); chk("R6", 16'hFFFF, 1'b1);
    set_gate(1'b1); chk("R6", 16'd3, 1'b0);
  endtask

  task automatic t_mode2();
    do_load(3'd2, 16'd4); chk("R2", 16'd4, 1'b1);
    cyc(); chk("R8", 16'd3, 1'b1);
    cyc(); chk("R8", 16'd2, 1'b1);
    cyc(); chk("R8", 16'd1, 1'b0);
    cyc(); chk("R8", 16'd4, 1'b1);
    cyc(); cyc(); cyc(); chk("R8", 16'd1, 1'b0);
    set_gate(1'b0); chk("R10", 16'd1, 1'b1);
    cyc(); chk("R10", 16'd1, 1'b1);
    set_gate(1'b1); chk("R10", 16'd4, 1'b1);
  endtask

  task automatic t_mode3();
    do_load(3'd3, 16'd5); chk("R2", 16'd6, 1'b1);
    cyc(); chk("R9", 16'd4, 1'b1);
    cyc(); chk("R9", 16'd2, 1'b1);
    cyc(); chk("R9", 16'd4, 1'b0);
    cyc(); chk("R9", 16'd2, 1'b0);
    cyc(); chk("R9", 16'd6, 1'b1);
    cyc(); cyc(); cyc(); chk("R9", 16'd4, 1'b0);
    set_gate(1'b0); chk("R10", 16'd4, 1'b1);
    cyc(); chk("R10", 16'd4, 1'b1);
    set_gate(1'b1); chk("R10", 16'd6, 1'b1);
    do_load(3'd3, 16'd4); chk("R9", 16'd4, 1'b1);
    cyc(); chk("R9", 16'd2, 1'b1);
    cyc(); chk("R9", 16'd4, 1'b0);
    cyc(); chk("R9", 16'd2, 1'b0);
    cyc(); chk("R9", 16'd4, 1'b1);
  endtask

  task automatic t_mode4();
    do_load(3'd4, 16'd2); chk("R2", 16'd2, 1'b1);
    cyc(); chk("R7", 16'd1, 1'b1);
    cyc(); chk("R7", 16'd0, 1'b0);
    cyc(); chk("R7", 16'hFFFF, 1'b1);
    do_load(3'd4, 16'd2);
    set_gate(1'b0); chk("R11", 16'd2, 1'b1);
    cyc(); chk("R11", 16'd2, 1'b1);
    set_gate(1'b1); chk("R11", 16'd2, 1'b1);
    cyc(); chk("R11", 16'd1, 1'b1);
  endtask

  task automatic t_mode5();
    set_gate(1'b0);
    do_load(3'd5, 16'd2); chk("R2", 16'd2, 1'b1);
    cyc(); chk("R6", 16'd2, 1'b1);
    set_gate(1'b1); chk("R6", 16'd2, 1'b1);
    cyc(); chk("R7", 16'd1, 1'b1);
    cyc(); chk("R7", 16'd0, 1'b0);
    cyc(); chk("R7", 16'hFFFF, 1'b1);
  endtask

  task automatic t_alias();
    do_load(3'd6, 16'd3); chk("R12", 16'd3, 1'b1);
    cyc(); chk("R12", 16'd2, 1'b1);
    cyc(); chk("R12", 16'd1, 1'b0);
    cyc(); chk("R12", 16'd3, 1'b1);
    do_load(3'd7, 16'd4); chk("R12", 16'd4, 1'b1);
    cyc(); chk("R12", 16'd2, 1'b1);
    cyc(); chk("R12", 16'd4, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode0();
    t_mode1();
    t_mode2();
    t_mode3();
    t_mode4();
    t_mode5();
    t_alias();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule